// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds or subtracts two wide operands as one full-width lane or as several independent narrower lanes, with the lane width chosen per operation at run time. At the default 64-bit width, the lanes can be 8, 16, 32 or 64 bits wide. A 16-bit selection, for example, performs four separate additions in the same cycle. A 32-bit selection treats each operand as a packed pair of elements. The carry chain is built from fixed-width segments. A segment that starts a lane takes the add/subtract carry-in instead of the carry from the segment below it, so no carry or borrow crosses a lane boundary.

Each lane computes in wrap-around or saturating arithmetic, and reads its operands as signed (two's complement) or unsigned. Every lane reports overflow whether or not saturation is on. When saturation is on, an overflowing lane is clamped to the extreme value on the side of the true result. The datapath is one combinational stage. A parameter can add a result register behind it. The block has no control state machine, so no states or transitions apply.

Top module: `simd_sat_adder`

## Requirements
- R1: The lanes are SEG_W << lane_sel bits wide. A lane_sel value that would give lanes wider than DATA_W selects one full-width lane. At the defaults, codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit lanes.
- R2: No carry or borrow passes from one lane into the next. Each lane's result depends only on that lane's bits of op_a and op_b.
- R3: With sat_en low, each lane result is (a + b) mod 2^L when do_sub is 0, and (a - b) mod 2^L when do_sub is 1, where L is the lane width.
- R4: In signed mode (is_signed=1), a lane overflows when its true result lies outside [-2^(L-1), 2^(L-1)-1]. With sat_en high, an overflowing lane becomes 2^(L-1)-1 if the true result is positive and -2^(L-1) if it is negative.
- R5: In unsigned mode (is_signed=0), an addition overflows on carry-out and a subtraction overflows on borrow. With sat_en high, an overflowing addition gives all ones and an overflowing subtraction gives zero.
- R6: ovf_o has one bit per SEG_W-bit segment, with bit k covering op bits [k*SEG_W +: SEG_W]. Every segment bit of a lane equals that lane's overflow, whatever the value of sat_en.
- R7: With OUT_REG=1, sum_o and ovf_o reflect the inputs sampled at the previous rising clock edge, and an active-low rst_n clears both to zero. With OUT_REG=0, both follow the inputs combinationally.
- R8: In wrap-around mode the result bits do not depend on is_signed. Only the overflow flags differ between the two modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Active-low reset of the result register |
| op_a | input | DATA_W | First operand (minuend when subtracting) |
| op_b | input | DATA_W | Second operand (subtrahend when subtracting) |
| lane_sel | input | CODE_W | Lane-width code, width SEG_W << lane_sel |
| do_sub | input | 1 | 1 selects subtract, 0 selects add |
| sat_en | input | 1 | 1 selects saturating arithmetic, 0 selects wrap-around |
| is_signed | input | 1 | 1 reads lanes as two's complement, 0 as unsigned |
| sum_o | output | DATA_W | Packed lane results |
| ovf_o | output | DATA_W/SEG_W | Overflow flag per segment, replicated across each lane |

## Verification
The bench builds two copies of the block. The first is a small registered one with DATA_W=16, SEG_W=4 and OUT_REG=1. With 4-bit lanes, it can sweep every operand pair in every lane under all eight add/sub, saturate and signedness combinations. Its lane_sel code 3 exceeds the datapath width, which tests the clamp to a single full-width lane. The second copy uses the default 64-bit, 8-bit-segment, combinational configuration. It is driven with pseudo-random and extreme-value vectors at every lane width, and its expected values come from wide integer arithmetic in the bench.

// File: rtl/simd_pkg.sv
package simd_pkg;

    // Number of bits for a lane-width code that can name every power-of-two
    // lane size from one segment up to all segments.
    function automatic int code_bits(input int nseg);
        int lg;
        lg = $clog2(nseg);
        return (lg < 1) ? 1 : $clog2(lg + 1);
    endfunction

    // Build a segment-wide saturation pattern.
    function automatic logic [63:0] clamp_pattern(input int w, input logic signed_mode,
                                                  input logic top_seg, input logic neg,
                                                  input logic sub);
        logic [63:0] p;
        p = '0;
        for (int j = 0; j < w; j++) begin
            if (!signed_mode)
                p[j] = ~sub;
            else if (top_seg && j == w - 1)
                p[j] = neg;
            else
                p[j] = ~neg;
        end
        return p;
    endfunction

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map #(
    parameter int NSEG   = 8,
    parameter int CODE_W = 2
) (
    input  logic [CODE_W-1:0] lane_sel,
    output logic [NSEG-1:0]   seg_first,
    output logic [NSEG-1:0]   seg_last
);
    localparam int LOG_NSEG = $clog2(NSEG);

    always_comb begin
        int code_c;
        int mask;
        code_c = (int'(lane_sel) > LOG_NSEG) ? LOG_NSEG : int'(lane_sel);
        mask   = (1 << code_c) - 1;
        for (int i = 0; i < NSEG; i++) begin
            seg_first[i] = ((i & mask) == 0);
            seg_last[i]  = ((i & mask) == mask);
        end
    end
endmodule

// File: rtl/simd_segment.sv
module simd_segment #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] a,
    input  logic [SEG_W-1:0] b,
    input  logic             sub,
    input  logic             cin,
    output logic [SEG_W-1:0] raw,
    output logic             cout,
    output logic             ovf_sgn,
    output logic             ovf_uns
);
    localparam int MSB = SEG_W - 1;

    logic [SEG_W-1:0] b_eff;
    logic             c_into_msb;

    always_comb begin
        b_eff         = sub ? ~b : b;
        {cout, raw}   = {1'b0, a} + {1'b0, b_eff} + {{SEG_W{1'b0}}, cin};
        c_into_msb    = a[MSB] ^ b_eff[MSB] ^ raw[MSB];
        ovf_sgn       = c_into_msb ^ cout;
        ovf_uns       = sub ? ~cout : cout;
    end
endmodule

// File: rtl/simd_sat_mux.sv
module simd_sat_mux #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] raw,
    input  logic             sat_en,
    input  logic             is_signed,
    input  logic             sub,
    input  logic             top_seg,
    input  logic             lane_ovf,
    input  logic             lane_neg,
    output logic [SEG_W-1:0] res
);
    import simd_pkg::*;

    logic [63:0] pat;

    always_comb begin
        pat = clamp_pattern(SEG_W, is_signed, top_seg, lane_neg, sub);
        res = (sat_en && lane_ovf) ? pat[SEG_W-1:0] : raw;
    end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
    parameter int DATA_W  = 64,
    parameter int SEG_W   = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int NSEG   = DATA_W / SEG_W,
    localparam int CODE_W = simd_pkg::code_bits(DATA_W / SEG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [CODE_W-1:0] lane_sel,
    input  logic              do_sub,
    input  logic              sat_en,
    input  logic              is_signed,
    output logic [DATA_W-1:0] sum_o,
    output logic [NSEG-1:0]   ovf_o
);
    logic [NSEG-1:0]   seg_first;
    logic [NSEG-1:0]   seg_last;
    logic [NSEG-1:0]   top_ovf;
    logic [NSEG-1:0]   top_neg;
    logic [NSEG-1:0]   lane_ovf;
    logic [NSEG-1:0]   lane_neg;
    logic [DATA_W-1:0] raw_sum;
    logic [DATA_W-1:0] comb_sum;

    simd_lane_map #(.NSEG(NSEG), .CODE_W(CODE_W)) u_map (
        .lane_sel  (lane_sel),
        .seg_first (seg_first),
        .seg_last  (seg_last)
    );

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        logic cin;
        logic co;
        logic o_s;
        logic o_u;

        if (i == 0) begin : g_first
            assign cin = do_sub;
        end else begin : g_chain
            assign cin = seg_first[i] ? do_sub : g_seg[i-1].co;
        end

        simd_segment #(.SEG_W(SEG_W)) u_seg (
            .a       (op_a[i*SEG_W +: SEG_W]),
            .b       (op_b[i*SEG_W +: SEG_W]),
            .sub     (do_sub),
            .cin     (cin),
            .raw     (raw_sum[i*SEG_W +: SEG_W]),
            .cout    (co),
            .ovf_sgn (o_s),
            .ovf_uns (o_u)
        );

        assign top_ovf[i] = is_signed ? o_s : o_u;
        assign top_neg[i] = op_a[i*SEG_W + SEG_W - 1];

        simd_sat_mux #(.SEG_W(SEG_W)) u_mux (
            .raw       (raw_sum[i*SEG_W +: SEG_W]),
            .sat_en    (sat_en),
            .is_signed (is_signed),
            .sub       (do_sub),
            .top_seg   (seg_last[i]),
            .lane_ovf  (lane_ovf[i]),
            .lane_neg  (lane_neg[i]),
            .res       (comb_sum[i*SEG_W +: SEG_W])
        );
    end

    // Broadcast each lane's top-segment overflow and sign down to its segments.
    always_comb begin
        logic run_ovf;
        logic run_neg;
        run_ovf = 1'b0;
        run_neg = 1'b0;
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (seg_last[i]) begin
                run_ovf = top_ovf[i];
                run_neg = top_neg[i];
            end
            lane_ovf[i] = run_ovf;
            lane_neg[i] = run_neg;
        end
    end

    if (OUT_REG) begin : g_reg
        logic started;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum_o   <= '0;
                ovf_o   <= '0;
                started <= 1'b0;
            end else begin
                sum_o   <= comb_sum;
                ovf_o   <= lane_ovf;
                started <= 1'b1;
            end
        end

        // R7
        out_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            started |-> (sum_o == $past(comb_sum) && ovf_o == $past(lane_ovf)));
    end else begin : g_comb
        assign sum_o = comb_sum;
        assign ovf_o = lane_ovf;
    end

    for (genvar i = 1; i < NSEG; i++) begin : g_edge_chk
        // R1
        lane_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seg_first[i] == seg_last[i-1]);
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_lane_chk
        // R4
        signed_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_last[i] && is_signed && !do_sub
             && op_a[i*SEG_W+SEG_W-1] == op_b[i*SEG_W+SEG_W-1]
             && raw_sum[i*SEG_W+SEG_W-1] != op_a[i*SEG_W+SEG_W-1]) |-> lane_ovf[i]);

        // R5
        uns_sat_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_last[i] && !is_signed && !do_sub && sat_en)
            |-> (comb_sum[i*SEG_W +: SEG_W] >= op_a[i*SEG_W +: SEG_W]));
    end

    // R8
    self_sub_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_sub && !sat_en && op_a == op_b) |-> (comb_sum == '0 && lane_ovf == '0));

endmodule

// File: tb/tb_simd_sat_adder.sv
module tb_simd_sat_adder;
    localparam int CLK_PERIOD = 10;
    localparam int S_W   = 16;
    localparam int S_SEG = 4;
    localparam int W_W   = 64;
    localparam int W_SEG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_tests = 0;
    int   n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [S_W-1:0] s_a, s_b, s_sum;
    logic [1:0]     s_sel;
    logic           s_sub, s_sat, s_sgn;
    logic [3:0]     s_ovf;

    logic [W_W-1:0] w_a, w_b, w_sum;
    logic [1:0]     w_sel;
    logic           w_sub, w_sat, w_sgn;
    logic [7:0]     w_ovf;

    simd_sat_adder #(.DATA_W(S_W), .SEG_W(S_SEG), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(s_a), .op_b(s_b), .lane_sel(s_sel),
        .do_sub(s_sub), .sat_en(s_sat), .is_signed(s_sgn),
        .sum_o(s_sum), .ovf_o(s_ovf)
    );

    simd_sat_adder #(.DATA_W(W_W), .SEG_W(W_SEG), .OUT_REG(1'b0)) dut_wide (
        .clk(clk), .rst_n(rst_n), .op_a(w_a), .op_b(w_b), .lane_sel(w_sel),
        .do_sub(w_sub), .sat_en(w_sat), .is_signed(w_sgn),
        .sum_o(w_sum), .ovf_o(w_ovf)
    );

    // Arithmetic reference model over arbitrary lane widths.
    task automatic model(input logic [63:0] a, input logic [63:0] b, input int dw,
                         input int segw, input int code, input logic sub,
                         input logic sat, input logic sgn,
                         output logic [63:0] res, output logic [15:0] fl);
        int L;
        L = segw << code;
        if (L > dw) L = dw;
        res = '0;
        fl  = '0;
        for (int base = 0; base < dw; base += L) begin
            logic signed [65:0] va, vb, t, mx, mn, r;
            logic ov;
            for (int j = 0; j < 66; j++) begin
                va[j] = (j < L) ? a[base+j] : (sgn ? a[base+L-1] : 1'b0);
                vb[j] = (j < L) ? b[base+j] : (sgn ? b[base+L-1] : 1'b0);
            end
            t  = sub ? va - vb : va + vb;
            mx = sgn ? (66'sd1 <<< (L-1)) - 66'sd1 : (66'sd1 <<< L) - 66'sd1;
            mn = sgn ? -(66'sd1 <<< (L-1)) : 66'sd0;
            ov = (t > mx) || (t < mn);
            r  = (ov && sat) ? ((t > mx) ? mx : mn) : t;
            for (int j = 0; j < L; j++) res[base+j] = r[j];
            for (int s = base / segw; s < (base + L) / segw; s++) fl[s] = ov;
        end
    endtask

    function automatic string mode_req(input logic sat, input logic sgn);
        if (sat) return sgn ? "R4" : "R5";
        return sgn ? "R8" : "R3";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_small(input logic [15:0] a, input logic [15:0] b, input int code,
                             input logic sub, input logic sat, input logic sgn,
                             input string req);
        logic [63:0] er;
        logic [15:0] ef;
        @(negedge clk);
        s_a = a; s_b = b; s_sel = code[1:0]; s_sub = sub; s_sat = sat; s_sgn = sgn;
        model({48'd0, a}, {48'd0, b}, S_W, S_SEG, code, sub, sat, sgn, er, ef);
        @(posedge clk);
        #1;
        check(req, {48'd0, s_sum}, er);
        check("R6", {60'd0, s_ovf}, {60'd0, ef[3:0]});
    endtask

    task automatic run_wide(input logic [63:0] a, input logic [63:0] b, input int code,
                            input logic sub, input logic sat, input logic sgn,
                            input string req);
        logic [63:0] er;
        logic [15:0] ef;
        @(negedge clk);
        w_a = a; w_b = b; w_sel = code[1:0]; w_sub = sub; w_sat = sat; w_sgn = sgn;
        model(a, b, W_W, W_SEG, code, sub, sat, sgn, er, ef);
        #1;
        check(req, w_sum, er);
        check("R6", {56'd0, w_ovf}, {56'd0, ef[7:0]});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        s_a = 16'hFFFF; s_b = 16'h0001; s_sel = 2'd0; s_sub = 1'b0; s_sat = 1'b1; s_sgn = 1'b0;
        w_a = '0; w_b = '0; w_sel = 2'd0; w_sub = 1'b0; w_sat = 1'b0; w_sgn = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R7 reset state
        check("R7", {48'd0, s_sum}, 64'd0);
        check("R7", {60'd0, s_ovf}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: carries stop at 4-bit lane edges
        run_small(16'h000F, 16'h0001, 0, 1'b0, 1'b0, 1'b0, "R2");
        run_small(16'h0F00, 16'h0100, 1, 1'b0, 1'b0, 1'b0, "R2");
        run_small(16'h0000, 16'h0001, 0, 1'b1, 1'b0, 1'b0, "R2");
        // R1: code 3 exceeds 16 bits, behaves as one full lane
        run_small(16'h7FFF, 16'h0001, 3, 1'b0, 1'b1, 1'b1, "R1");
        run_small(16'h00FF, 16'h0001, 3, 1'b0, 1'b0, 1'b0, "R1");

        // R7 latency: output holds until the next rising edge
        @(negedge clk);
        s_a = 16'h1234; s_b = 16'h1111; s_sel = 2'd2; s_sub = 1'b0; s_sat = 1'b0; s_sgn = 1'b0;
        @(posedge clk);
        @(negedge clk);
        s_a = 16'h0000; s_b = 16'h0000;
        #1;
        check("R7", {48'd0, s_sum}, 64'h2345);
        @(posedge clk);
        #1;
        check("R7", {48'd0, s_sum}, 64'h0000);

        // Exhaustive 4-bit lane sweep, all modes (R3, R4, R5, R8)
        for (int m = 0; m < 8; m++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    logic [3:0] xa, yb;
                    xa = x[3:0]; yb = y[3:0];
                    run_small({~xa, xa ^ 4'h5, yb, xa}, {yb, yb + 4'h3, xa, yb}, 0,
                              m[0], m[1], m[2], mode_req(m[1], m[2]));
                end
            end
        end

        // Wider lanes on the small build
        for (int m = 0; m < 8; m++) begin
            for (int c = 1; c < 4; c++) begin
                for (int k = 0; k < 250; k++) begin
                    logic [31:0] r;
                    r = $urandom;
                    run_small(r[15:0], r[31:16], c, m[0], m[1], m[2], mode_req(m[1], m[2]));
                end
            end
        end

        // 64-bit build: four 16-bit adds in one operation (R1)
        run_wide(64'h7FFF_0001_FFFF_8000, 64'h0001_0001_0001_8000, 1, 1'b0, 1'b1, 1'b1, "R1");
        run_wide(64'h7FFF_0001_FFFF_8000, 64'h0001_0001_0001_8000, 1, 1'b0, 1'b0, 1'b0, "R1");
        // packed 32-bit pair
        run_wide(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2, 1'b1, 1'b1, 1'b1, "R4");

        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 4; c++) begin
                run_wide({8{8'h7F}}, {8{8'h01}}, c, m[0], m[1], m[2], mode_req(m[1], m[2]));
                run_wide({8{8'h80}}, {8{8'h80}}, c, m[0], m[1], m[2], mode_req(m[1], m[2]));
                run_wide({8{8'h00}}, {8{8'hFF}}, c, m[0], m[1], m[2], mode_req(m[1], m[2]));
                for (int k = 0; k < 100; k++) begin
                    run_wide({$urandom, $urandom}, {$urandom, $urandom}, c,
                             m[0], m[1], m[2], mode_req(m[1], m[2]));
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule